// File: doc/BRIEF.md
# Conditional-Sum Adder

This block adds two W-bit operands and a carry-in. It selects carries recursively instead of rippling them. Every bit position starts as a 1-bit block that holds two candidate results: one for an incoming carry of 0 and one for an incoming carry of 1. Merge levels then join neighbouring blocks, so the block width doubles at each level. In a merge, the lower block's candidate carry for a given assumption picks the upper block's candidate for that same assumption. The lower block's sum bits pass through unchanged. After log2 W levels, a single block spans the whole word, and the real carry-in picks one of its two results.

The addition is combinational. The chosen sum and carry-out are captured in an output register, so a result appears at the outputs one clock edge after the operands are presented. A synchronous, active-high reset clears that register. The width W must be a power of two and at least 2.

Top module: `csum_adder`

## Requirements
- R1: One rising clock edge after an edge at which rst is low, {cout, sum} equals opa + opb + cin taken over W+1 bits, computed from the operand and carry-in values present at the earlier edge.
- R2: At any rising edge at which rst is high, sum and cout become all zeros at that edge, whatever the inputs are.
- R3: A carry crosses every block boundary. With opa all ones, opb zero and cin = 1, the result is sum = 0 and cout = 1. With both operands all ones and cin = 1, the result is sum all ones and cout = 1.
- R4: For any operands, the carry-out with cin = 1 is never 0 while the carry-out with cin = 0 is 1.
- R5: For any operands, the (W+1)-bit result with cin = 1 is exactly one greater than the result with cin = 0.
- R6: The registered result equals the block-wide candidate that assumed carry-in 0 when cin was 0, and the candidate that assumed carry-in 1 when cin was 1.
- R7: The structure is correct for every power-of-two width. Instances with W = 4 and W = 8 are correct for all operand and carry-in combinations, and an instance with W = 32 is correct on directed and random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Registered sum |
| cout | output | 1 | Registered carry out of bit W-1 |

## Verification
A reset and a new addition can fall on the same clock edge. The bench raises rst while nonzero operands are driven and the register already holds a nonzero result. It then expects zeros at that edge, and the correct sum one edge after rst drops. At every edge, the output register also receives a carry-in choice and a full-width carry resolution at once. Both candidates are observed at the ports: each 8-bit operand pair is applied with cin = 0 and then with cin = 1, and the bench checks that the second result is one above the first and that its carry never falls below the first one's.

// File: rtl/csum_pkg.sv
package csum_pkg;

  // Number of merge levels above the 1-bit blocks.
  function automatic int unsigned csum_levels(input int unsigned width);
    return $clog2(width);
  endfunction

  // True when width is a nonzero power of two.
  function automatic bit csum_is_pow2(input int unsigned width);
    return (width != 0) && ((width & (width - 1)) == 0);
  endfunction

endpackage

// File: rtl/csum_leaf.sv
module csum_leaf (
  input  logic x,
  input  logic y,
  output logic s_lo,   // sum assuming incoming carry 0
  output logic c_lo,   // carry assuming incoming carry 0
  output logic s_hi,   // sum assuming incoming carry 1
  output logic c_hi    // carry assuming incoming carry 1
);
  logic half;

  assign half = x ^ y;
  assign s_lo = half;
  assign c_lo = x & y;
  assign s_hi = ~half;
  assign c_hi = x | y;
endmodule

// File: rtl/csum_merge.sv
module csum_merge #(
  parameter int unsigned H = 1   // width of each half
) (
  input  logic [H-1:0]   lo_s_lo,
  input  logic [H-1:0]   lo_s_hi,
  input  logic           lo_c_lo,
  input  logic           lo_c_hi,
  input  logic [H-1:0]   up_s_lo,
  input  logic [H-1:0]   up_s_hi,
  input  logic           up_c_lo,
  input  logic           up_c_hi,
  output logic [2*H-1:0] s_lo,
  output logic [2*H-1:0] s_hi,
  output logic           c_lo,
  output logic           c_hi
);
  // Lower carry under each assumption picks the matching upper candidate.
  always_comb begin
    if (lo_c_lo) begin
      s_lo = {up_s_hi, lo_s_lo};
      c_lo = up_c_hi;
    end else begin
      s_lo = {up_s_lo, lo_s_lo};
      c_lo = up_c_lo;
    end
    if (lo_c_hi) begin
      s_hi = {up_s_hi, lo_s_hi};
      c_hi = up_c_hi;
    end else begin
      s_hi = {up_s_lo, lo_s_hi};
      c_hi = up_c_lo;
    end
  end
endmodule

// File: rtl/csum_tree.sv
module csum_tree #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_lo,
  output logic [W-1:0] sum_hi,
  output logic         cry_lo,
  output logic         cry_hi
);
  localparam int unsigned LV = csum_pkg::csum_levels(W);

  if (!csum_pkg::csum_is_pow2(W) || W < 2) begin : g_bad_width
    $error("csum_tree: W must be a power of two and at least 2");
  end

  for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
    localparam int unsigned N = W >> lv;        // blocks at this level
    localparam int unsigned BW = 1 << lv;       // block width at this level
    logic [W-1:0] s_lo;
    logic [W-1:0] s_hi;
    logic [N-1:0] c_lo;
    logic [N-1:0] c_hi;

    if (lv == 0) begin : g_leaves
      for (genvar i = 0; i < W; i++) begin : g_bit
        csum_leaf u_leaf (
          .x    (a[i]),
          .y    (b[i]),
          .s_lo (s_lo[i]),
          .c_lo (c_lo[i]),
          .s_hi (s_hi[i]),
          .c_hi (c_hi[i])
        );
      end
    end else begin : g_merges
      localparam int unsigned H = BW / 2;
      for (genvar k = 0; k < N; k++) begin : g_blk
        csum_merge #(.H(H)) u_merge (
          .lo_s_lo (g_lv[lv-1].s_lo[k*BW +: H]),
          .lo_s_hi (g_lv[lv-1].s_hi[k*BW +: H]),
          .lo_c_lo (g_lv[lv-1].c_lo[2*k]),
          .lo_c_hi (g_lv[lv-1].c_hi[2*k]),
          .up_s_lo (g_lv[lv-1].s_lo[k*BW+H +: H]),
          .up_s_hi (g_lv[lv-1].s_hi[k*BW+H +: H]),
          .up_c_lo (g_lv[lv-1].c_lo[2*k+1]),
          .up_c_hi (g_lv[lv-1].c_hi[2*k+1]),
          .s_lo    (s_lo[k*BW +: BW]),
          .s_hi    (s_hi[k*BW +: BW]),
          .c_lo    (c_lo[k]),
          .c_hi    (c_hi[k])
        );
      end
    end
  end

  assign sum_lo = g_lv[LV].s_lo;
  assign sum_hi = g_lv[LV].s_hi;
  assign cry_lo = g_lv[LV].c_lo[0];
  assign cry_hi = g_lv[LV].c_hi[0];
endmodule

// File: rtl/csum_adder.sv
module csum_adder #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] t_sum_lo;
  logic [W-1:0] t_sum_hi;
  logic         t_cry_lo;
  logic         t_cry_hi;
  logic [W-1:0] nxt_sum;
  logic         nxt_cout;

  csum_tree #(.W(W)) u_tree (
    .a      (opa),
    .b      (opb),
    .sum_lo (t_sum_lo),
    .sum_hi (t_sum_hi),
    .cry_lo (t_cry_lo),
    .cry_hi (t_cry_hi)
  );

  // Real carry-in resolves the block-wide candidates.
  always_comb begin
    if (cin) begin
      nxt_sum  = t_sum_hi;
      nxt_cout = t_cry_hi;
    end else begin
      nxt_sum  = t_sum_lo;
      nxt_cout = t_cry_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= nxt_sum;
      cout <= nxt_cout;
    end
  end

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout, sum} == ({1'b0, $past(opa)} + {1'b0, $past(opb)}
                              + {{W{1'b0}}, $past(cin)})));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum == '0 && cout == 1'b0));

  // R3
  full_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (&opa && opb == '0 && cin) |=> (sum == '0 && cout));

  // R4
  carry_mono_chk: assert property (@(posedge clk) disable iff (rst)
    t_cry_lo |-> t_cry_hi);

  // R5
  cand_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ({t_cry_hi, t_sum_hi} == {t_cry_lo, t_sum_lo} + 1'b1));

  // R6
  pick_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !cin |=> ({cout, sum} == $past({t_cry_lo, t_sum_lo})));

  // R6
  pick_hi_chk: assert property (@(posedge clk) disable iff (rst)
    cin |=> ({cout, sum} == $past({t_cry_hi, t_sum_hi})));
endmodule

// File: tb/test_csum_adder.sv
module test_csum_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [3:0]  a4 = '0, b4 = '0;  logic c4 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;  logic c8 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0; logic c32 = 1'b0;
  logic [3:0]  s4;  logic o4;
  logic [7:0]  s8;  logic o8;
  logic [31:0] s32; logic o32;

  csum_adder #(.W(4)) i_csum_adder_w4 (
    .clk(clk), .rst(rst), .opa(a4), .opb(b4), .cin(c4), .sum(s4), .cout(o4));
  csum_adder #(.W(8)) i_csum_adder_w8 (
    .clk(clk), .rst(rst), .opa(a8), .opb(b8), .cin(c8), .sum(s8), .cout(o8));
  csum_adder #(.W(32)) i_csum_adder (
    .clk(clk), .rst(rst), .opa(a32), .opb(b32), .cin(c32), .sum(s32), .cout(o32));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int NT = 8;
  localparam logic [31:0] T_A [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,
    32'h8000_0000, 32'h1234_5678, 32'h0000_FFFF, 32'h7FFF_FFFF, 32'hAAAA_AAAA};
  localparam logic [31:0] T_B [NT] = '{32'h0, 32'hFFFF_FFFF, 32'h0,
    32'h8000_0000, 32'h1111_1111, 32'h0000_0001, 32'h0, 32'h5555_5555};
  localparam logic T_C [NT] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [32:0] T_E [NT] = '{33'h1_0000_0000, 33'h1_FFFF_FFFF, 33'h0,
    33'h1_0000_0000, 33'h0_2345_6789, 33'h0_0001_0000, 33'h0_8000_0000,
    33'h1_0000_0000};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the next rising edge.
  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [8:0] r0, r1;
    logic [32:0] e32;
    // R2: reset with nonzero inputs
    @(negedge clk);
    a4 = 4'hF; b4 = 4'h1; c4 = 1; a8 = 8'hAB; b8 = 8'h77; c8 = 1;
    a32 = 32'hDEAD_BEEF; b32 = 32'h1; c32 = 1;
    tick();
    chk("R2 reset w4", {59'd0, o4, s4}, 64'd0);
    chk("R2 reset w8", {55'd0, o8, s8}, 64'd0);
    chk("R2 reset w32", {31'd0, o32, s32}, 64'd0);
    @(negedge clk); rst = 0;
    tick();
    chk("R1 first after reset w32", {31'd0, o32, s32}, 64'h0_DEAD_BEF1);

    // R1 R7: table of 32-bit vectors
    for (int i = 0; i < NT; i++) begin
      @(negedge clk); a32 = T_A[i]; b32 = T_B[i]; c32 = T_C[i];
      tick();
      chk((i < 2) ? "R3 carry across all blocks w32" : "R1 table w32",
          {31'd0, o32, s32}, {31'd0, T_E[i]});
    end

    // R7 R1: exhaustive 4-bit
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk); a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
          tick();
          chk("R7 exhaustive w4", {59'd0, o4, s4}, 64'(a + b + c));
        end
      end
    end

    // R7 R4 R5 R6: exhaustive 8-bit, each pair with cin 0 then 1
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk); a8 = 8'(a); b8 = 8'(b); c8 = 0;
        tick();
        r0 = {o8, s8};
        @(negedge clk); c8 = 1;
        tick();
        r1 = {o8, s8};
        chk("R6 cin0 w8", {55'd0, r0}, 64'(a + b));
        chk("R7 exhaustive w8", {55'd0, r1}, 64'(a + b + 1));
        chk("R5 step of one w8", {55'd0, r1}, {55'd0, 9'(r0 + 9'd1)});
        chk("R4 carry order w8", {63'd0, !(r0[8] && !r1[8])}, 64'd1);
      end
    end

    // R1: random 32-bit
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
      e32 = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
      tick();
      chk("R1 random w32", {31'd0, o32, s32}, {31'd0, e32});
    end

    // R2: reset lands on a cycle with a nonzero result and new operands
    @(negedge clk); a32 = 32'h0F0F_0F0F; b32 = 32'h1010_1010; c32 = 0;
    tick();
    chk("R1 before mid reset w32", {31'd0, o32, s32}, 64'h0_1F1F_1F1F);
    @(negedge clk); rst = 1; a32 = 32'hFFFF_FFFF; b32 = 32'h2; c32 = 1;
    tick();
    chk("R2 mid-run reset w32", {31'd0, o32, s32}, 64'd0);
    @(negedge clk); rst = 0;
    tick();
    chk("R1 after mid reset w32", {31'd0, o32, s32}, 64'h1_0000_0002);

    // R3: 8-bit directed full propagate
    @(negedge clk); a8 = 8'hFF; b8 = 8'h00; c8 = 1;
    tick();
    chk("R3 carry across all blocks w8", {55'd0, o8, s8}, 64'h100);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule